// File: doc/BRIEF.md
# Parallel-to-serial transmitter with loopback paths

The block takes a parallel word, one per byte period, and sends it out as a serial bit stream with one bit per cycle of the bit clock. The word is first captured into a holding register on the rising edge of a parallel input clock. A load strobe, made in the bit-clock domain, then copies it into a shift register that is loadable in parallel. The most significant bit leaves first. Because the strobe is placed on the last bit of the word before, the words follow each other with no gap.

The bit clock is divided by the word width to give a byte-rate clock output. Upstream logic uses it to launch words, and it is usually fed back as the parallel input clock. Two active-low controls select the loopback paths. The line loopback control replaces the serializer's data and clock on the main serial outputs with an external data/clock pair. The diagnostic loopback control enables a second serial output pair. The clock of that pair follows the bit clock, and its data is retimed on the falling edge. When the control is off, both outputs of the pair are held low.

Top module: `ser16_lb_tx`

## Requirements
- R1: A WORD_W-bit word (default 16) on `par_data_i` is captured on the rising edge of `par_clk_i` into a holding register. Changes on `par_data_i` between captures do not reach the serial stream.
- R2: Each word is sent most significant bit first (bit 15 for the default width) and least significant bit last, one bit per rising edge of `bit_clk_i`.
- R3: The shift register takes the holding register's contents on the edge that ends a load-strobe cycle. Successive words follow each other on `ser_data_o` with no idle bit between them.
- R4: The load strobe is high for exactly one bit-clock cycle out of every WORD_W: the cycle in which the last bit of the previous word is on the output. The first word appears on the WORD_W-th rising bit-clock edge after reset is released.
- R5: `byte_clk_o` is the bit clock divided by WORD_W. After the n-th rising bit-clock edge that follows reset release, it equals 1 when (n mod WORD_W) >= WORD_W/2, and 0 otherwise.
- R6: While `rst_n_i` is low, `byte_clk_o` stays low and does not toggle, and `ser_data_o` is 0. After release, `ser_data_o` stays 0 until the first word is loaded.
- R7: When `line_lb_n_i` is 0, `ser_data_o` carries `lb_data_i` and `ser_clk_o` carries `lb_clk_i`. When it is 1, they carry the shifter's output bit and `bit_clk_i`.
- R8: When `diag_lb_n_i` is 1, `diag_data_o` and `diag_clk_o` are held at 0, and the main serial outputs are not affected.
- R9: When `diag_lb_n_i` is 0, `diag_clk_o` follows `bit_clk_i`, and `diag_data_o` changes on its falling edge to the serializer's current bit. This holds whatever the line loopback setting is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| par_clk_i | input | 1 | Parallel input clock; its rising edge captures the word |
| par_data_i | input | WORD_W | Parallel word, MSB sent first |
| line_lb_n_i | input | 1 | Line loopback select, active low |
| lb_data_i | input | 1 | External loopback serial data |
| lb_clk_i | input | 1 | External loopback serial clock |
| diag_lb_n_i | input | 1 | Diagnostic loopback enable, active low |
| ser_data_o | output | 1 | Main serial data |
| ser_clk_o | output | 1 | Main serial clock |
| diag_data_o | output | 1 | Diagnostic serial data, retimed on the falling edge |
| diag_clk_o | output | 1 | Diagnostic serial clock |
| byte_clk_o | output | 1 | Bit clock divided by WORD_W |

## Verification
The bench builds the block with the default WORD_W of 16 and feeds `byte_clk_o` back as the parallel input clock. With that width, a complete byte-clock period, the first-load point and a dozen back-to-back words all fit within about two hundred bit cycles. The bench drives a correct word only in the cycle before each capture and drives corrupted data in every other cycle, so any path that skips the holding register shows up. The two loopback controls are switched in windows that overlap each other, which checks that the main path and the diagnostic path stay independent.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic {
        SRC_SHIFT = 1'b0,
        SRC_LINE  = 1'b1
    } tx_src_e;

    function automatic tx_src_e pick_src(input logic line_lb_n);
        return line_lb_n ? SRC_SHIFT : SRC_LINE;
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int WORD_W = 16
) (
    input  logic bit_clk_i,
    input  logic rst_n_i,
    output logic load_o,
    output logic byte_clk_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pclk;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.pclk = st_d.cnt[CNT_W-1];
    end

    always_ff @(posedge bit_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign load_o     = (st_q.cnt == LAST);
    assign byte_clk_o = st_q.pclk;

    // Load happens in the high half of the byte clock, which falls right after.
    p_load_in_high_half_r4: assert property (@(posedge bit_clk_i) disable iff (!rst_n_i)
        load_o |-> byte_clk_o);
    p_byte_clk_falls_after_load_r5: assert property (@(posedge bit_clk_i) disable iff (!rst_n_i)
        load_o |=> !byte_clk_o);

endmodule

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg #(
    parameter int WORD_W = 16
) (
    input  logic              par_clk_i,
    input  logic              rst_n_i,
    input  logic [WORD_W-1:0] par_data_i,
    output logic [WORD_W-1:0] hold_o
);
    logic [WORD_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = par_data_i;
    end

    always_ff @(posedge par_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) hold_q <= '0;
        else          hold_q <= hold_d;
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              bit_clk_i,
    input  logic              rst_n_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] hold_i,
    output logic              bit_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.sh = hold_i;
        else        st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge bit_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign bit_o = st_q.sh[WORD_W-1];

    p_load_takes_hold_r3: assert property (@(posedge bit_clk_i) disable iff (!rst_n_i)
        load_i |=> (bit_o == $past(hold_i[WORD_W-1])));
    p_msb_first_order_r2: assert property (@(posedge bit_clk_i) disable iff (!rst_n_i)
        !load_i |=> (bit_o == $past(st_q.sh[WORD_W-2])));

endmodule

// File: rtl/sertx_out_sel.sv
module sertx_out_sel
    import sertx_pkg::*;
(
    input  logic bit_clk_i,
    input  logic rst_n_i,
    input  logic shift_bit_i,
    input  logic line_lb_n_i,
    input  logic lb_data_i,
    input  logic lb_clk_i,
    input  logic diag_lb_n_i,
    output logic ser_data_o,
    output logic ser_clk_o,
    output logic diag_data_o,
    output logic diag_clk_o
);
    tx_src_e src;
    logic    diag_d, diag_q;

    always_comb begin
        diag_d = shift_bit_i;
    end

    always_ff @(negedge bit_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) diag_q <= 1'b0;
        else          diag_q <= diag_d;
    end

    always_comb begin
        src = pick_src(line_lb_n_i);
        if (src == SRC_LINE) begin
            ser_data_o = lb_data_i;
            ser_clk_o  = lb_clk_i;
        end else begin
            ser_data_o = shift_bit_i;
            ser_clk_o  = bit_clk_i;
        end
        diag_data_o = diag_q & ~diag_lb_n_i;
        diag_clk_o  = bit_clk_i & ~diag_lb_n_i;
    end

    p_diag_tracks_serializer_r9: assert property (@(posedge bit_clk_i) disable iff (!rst_n_i)
        !diag_lb_n_i |-> (diag_data_o == shift_bit_i));

endmodule

// File: rtl/ser16_lb_tx.sv
module ser16_lb_tx #(
    parameter int WORD_W = 16
) (
    input  logic              bit_clk_i,
    input  logic              rst_n_i,
    input  logic              par_clk_i,
    input  logic [WORD_W-1:0] par_data_i,
    input  logic              line_lb_n_i,
    input  logic              lb_data_i,
    input  logic              lb_clk_i,
    input  logic              diag_lb_n_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              diag_data_o,
    output logic              diag_clk_o,
    output logic              byte_clk_o
);
    logic              load;
    logic [WORD_W-1:0] hold;
    logic              shift_bit;

    sertx_bit_timer #(.WORD_W(WORD_W)) u_timer (
        .bit_clk_i  (bit_clk_i),
        .rst_n_i    (rst_n_i),
        .load_o     (load),
        .byte_clk_o (byte_clk_o)
    );

    sertx_hold_reg #(.WORD_W(WORD_W)) u_hold (
        .par_clk_i  (par_clk_i),
        .rst_n_i    (rst_n_i),
        .par_data_i (par_data_i),
        .hold_o     (hold)
    );

    sertx_shifter #(.WORD_W(WORD_W)) u_shift (
        .bit_clk_i (bit_clk_i),
        .rst_n_i   (rst_n_i),
        .load_i    (load),
        .hold_i    (hold),
        .bit_o     (shift_bit)
    );

    sertx_out_sel u_out (
        .bit_clk_i   (bit_clk_i),
        .rst_n_i     (rst_n_i),
        .shift_bit_i (shift_bit),
        .line_lb_n_i (line_lb_n_i),
        .lb_data_i   (lb_data_i),
        .lb_clk_i    (lb_clk_i),
        .diag_lb_n_i (diag_lb_n_i),
        .ser_data_o  (ser_data_o),
        .ser_clk_o   (ser_clk_o),
        .diag_data_o (diag_data_o),
        .diag_clk_o  (diag_clk_o)
    );

    // While reset is held the byte clock stays low.
    p_byte_clk_quiet_in_reset_r6: assert property (@(posedge bit_clk_i)
        disable iff (rst_n_i) !byte_clk_o);

endmodule

// File: tb/ser16_lb_tx_tb_top.sv
`timescale 1ns/1ps
module ser16_lb_tx_tb_top;
    logic        bit_clk = 1'b0;
    logic        rst_n;
    logic        par_clk;
    logic [15:0] par_data;
    logic        line_n, lb_data, lb_clk, diag_n;
    logic        ser_data, ser_clk, diag_data, diag_clk, byte_clk;

    always #2.5 bit_clk = ~bit_clk;
    assign par_clk = byte_clk;

    ser16_lb_tx #(.WORD_W(16)) dut_i (
        .bit_clk_i   (bit_clk),
        .rst_n_i     (rst_n),
        .par_clk_i   (par_clk),
        .par_data_i  (par_data),
        .line_lb_n_i (line_n),
        .lb_data_i   (lb_data),
        .lb_clk_i    (lb_clk),
        .diag_lb_n_i (diag_n),
        .ser_data_o  (ser_data),
        .ser_clk_o   (ser_clk),
        .diag_data_o (diag_data),
        .diag_clk_o  (diag_clk),
        .byte_clk_o  (byte_clk)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [15:0] words [0:15];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Serial bit expected after the t-th bit edge since release.
    function automatic logic exp_bit(input int t);
        if (t < 16) return 1'b0;
        return words[t/16 - 1][15 - (t % 16)];
    endfunction

    initial begin
        words[0] = 16'hA5C3;
        words[1] = 16'hFFFF;
        words[2] = 16'h0000;
        words[3] = 16'h8001;
        words[4] = 16'h1234;
        for (int k = 5; k < 16; k++) words[k] = 16'(k * 16'h1357) ^ 16'hBEEF;

        rst_n = 1'b0; par_data = 16'h0; line_n = 1'b1; diag_n = 1'b1;
        lb_data = 1'b0; lb_clk = 1'b0;

        for (int i = 0; i < 4; i++) begin
            @(negedge bit_clk); #1;
            chk("R6 byte clock quiet in reset", byte_clk, 0);
            chk("R6 serial zero in reset", ser_data, 0);
        end

        @(negedge bit_clk);
        rst_n = 1'b1;
        par_data = ~words[0];
        for (int t = 1; t <= 200; t++) begin
            @(posedge bit_clk); #1;
            if (t == 20) chk("R7 main clock follows bit clock", ser_clk, 1);
            if (t == 70) chk("R9 diag clock follows bit clock", diag_clk, 1);
            if (t == 40) chk("R8 diag clock quiet", diag_clk, 0);
            @(negedge bit_clk);
            // R1: the right word is only present in the cycle before capture.
            par_data = (t % 16 == 7) ? words[t/16] : (~words[t/16] ^ 16'h5A5A);
            diag_n  = !(t >= 64 && t < 128);
            line_n  = !(t >= 112 && t < 168);
            lb_data = t[0] ^ t[2];
            lb_clk  = t[1];
            #1;
            chk("R5 byte clock phase", byte_clk, ((t % 16) >= 8) ? 1 : 0);
            if (t == 15) chk("R6 zero before first load", ser_data, 0);
            if (t == 16 && line_n) chk("R4 first word on 16th edge", ser_data, words[0][15]);
            if (line_n) begin
                chk((t % 16 == 0) ? "R3 word boundary bit" : "R2 R1 serial bit", ser_data, exp_bit(t));
                chk("R7 main clock is bit clock", ser_clk, 0);
            end else begin
                chk("R7 line loopback data", ser_data, lb_data);
                chk("R7 line loopback clock", ser_clk, lb_clk);
            end
            if (diag_n) begin
                chk("R8 diag data quiet", diag_data, 0);
                chk("R8 diag clock quiet", diag_clk, 0);
            end else begin
                chk("R9 diag data retimed", diag_data, exp_bit(t));
                chk("R9 diag clock low phase", diag_clk, 0);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule